// File: doc/BRIEF.md
# SPI Master with Register Port and Word FIFOs

This block is a SPI bus master driven through a small 32-bit register port. Software writes words into a transmit FIFO. A shift engine sends each word on MOSI while it captures MISO, and every finished word lands in a receive FIFO that software drains. The SCK half period and the word width are fixed by parameters. Clock polarity, clock phase, bit order and an internal loopback are set in the control register.

A hold bit lets software queue a whole burst before any bit moves. Clearing the hold bit releases the queued words back to back. Slave-select lines are active-low and come straight from a register. In manual mode they follow that register at all times. In automatic mode they follow it only while a word is shifting. An external select input from another master raises a sticky fault that stops new words from starting. Single-cycle pulses flag a finished burst, a dropped transmit write and a read from an empty receive FIFO.

Top module: `spi_host_ctrl`

## Requirements
- R1: Register offsets: 0x60 control, 0x64 status, 0x68 transmit data (write), 0x6C receive data (read), 0x70 slave select. Control bits: 0 loopback, 1 enable, 2 master, 3 CPOL, 4 CPHA, 5 TX FIFO clear, 6 RX FIFO clear, 7 manual select, 8 hold (transmit inhibit), 9 LSB first. After reset, control reads 0, slave select reads all ones in its NUM_SS bits, every ss_n is high and sck is low.
- R2: Status bits: 0 RX empty, 1 RX full, 2 TX empty, 3 TX full, 4 mode fault. After reset, status reads 0x05.
- R3: A word leaves the TX FIFO only when enable and master are 1, hold is 0 and no mode fault is flagged. While hold is 1, sck does not toggle and the TX FIFO keeps its contents.
- R4: sck rests at CPOL between words. Each word has WORD_W leading and WORD_W trailing edges, spaced SCK_HALF clock cycles apart. With CPHA=0 a bit is on MOSI before its leading edge and MISO is sampled on the leading edge. With CPHA=1 MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: Bits go out and come in most significant first when control bit 9 is 0, and least significant first when it is 1.
- R6: Each word sent pushes one received word into the RX FIFO. A read at 0x6C returns the oldest word and removes it. A word that arrives while the RX FIFO is full is discarded.
- R7: With loopback set, the receiver takes the MOSI stream and ignores the miso pin, so each received word equals the word sent.
- R8: Writing 1 to control bit 5 or 6 empties the TX or RX FIFO in one cycle. Both bits read back as 0, and the other control bits (loopback included) read back as written.
- R9: A transmit write while the TX FIFO is full is dropped and tx_overrun is high for one cycle after the write. A receive read while the RX FIFO is empty returns 0, and rx_underrun is high for one cycle after the read.
- R10: tx_done pulses for one cycle after a word finishes with the TX FIFO empty, so a back-to-back burst gives exactly one pulse.
- R11: In manual mode ss_n equals the low NUM_SS bits of the select register. In automatic mode ss_n is all ones while idle and equals those bits while a word shifts.
- R12: fault_sel_n low while enable and master are set raises status bit 4. The bit stays set and blocks new words until software writes 1 to status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX at 0x6C) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |
| fault_sel_n | input | 1 | Select from another master (active low, asynchronous) |
| tx_done | output | 1 | Burst finished pulse |
| tx_overrun | output | 1 | Dropped transmit write pulse |
| rx_underrun | output | 1 | Empty receive read pulse |

## Verification
The bench drives the shift engine against a behavioural slave that follows the mode the bench has chosen. It runs all eight combinations of polarity, phase and bit order, using words whose bit-reversed forms differ. A wrong sampling edge or a reversed order therefore corrupts the received word, the word the slave captured, or both. Loopback bursts with distinct words check that FIFO order is kept, that the hold gate works, and that a word arriving at a full receiver is dropped rather than overwriting. Directed cases cover the FIFO clears, the select modes and the fault lockout.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;
   localparam logic [7:0] OFS_CTRL = 8'h60;
   localparam logic [7:0] OFS_STAT = 8'h64;
   localparam logic [7:0] OFS_TXD  = 8'h68;
   localparam logic [7:0] OFS_RXD  = 8'h6C;
   localparam logic [7:0] OFS_SSEL = 8'h70;
   localparam int STAT_FAULT_BIT = 4;

   // packed: first member is the most significant bit (bit 9)
   typedef struct packed {
      logic lsb_first;
      logic hold;
      logic manual_ss;
      logic rx_clr;
      logic tx_clr;
      logic cpha;
      logic cpol;
      logic master;
      logic enable;
      logic loop;
   } ctrl_t;

   typedef struct packed {
      logic cpol;
      logic cpha;
      logic lsb_first;
   } wire_mode_t;
endpackage

// File: rtl/spi_host_fifo.sv
`timescale 1ns/1ps
module spi_host_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rp, wp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp] <= din;
   end
endmodule

// File: rtl/spi_host_shifter.sv
`timescale 1ns/1ps
module spi_host_shifter
   import spi_host_pkg::*;
#(
   parameter int W        = 8,
   parameter int SCK_HALF = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] word_in,
   input  wire_mode_t   mode,
   input  logic         loop,
   input  logic         miso,
   output logic         busy,
   output logic         sck,
   output logic         mosi,
   output logic         done,
   output logic [W-1:0] rx_word
);
   localparam int DW = $clog2(SCK_HALF + 1);
   localparam int EW = $clog2(2 * W);
   localparam logic [DW-1:0] DIV_LAST  = DW'(SCK_HALF - 1);
   localparam logic [EW-1:0] EDGE_LAST = EW'(2 * W - 1);

   function automatic logic out_bit(input logic [W-1:0] v, input logic lsb);
      return lsb ? v[0] : v[W-1];
   endfunction

   function automatic logic [W-1:0] step_out(input logic [W-1:0] v, input logic lsb);
      return lsb ? (v >> 1) : (v << 1);
   endfunction

   function automatic logic [W-1:0] step_in(input logic [W-1:0] v, input logic b,
                                            input logic lsb);
      return lsb ? {b, v[W-1:1]} : {v[W-2:0], b};
   endfunction

   wire_mode_t    mode_q;
   logic [DW-1:0] div_cnt;
   logic [EW-1:0] edge_cnt;
   logic [W-1:0]  tx_sh, rx_sh, rx_nxt;
   logic          sck_q, mosi_q;
   logic          edge_now, leading, last_edge, drive_now, sample_now, in_bit;

   assign edge_now   = busy && (div_cnt == DIV_LAST);
   assign leading    = !edge_cnt[0];
   assign last_edge  = (edge_cnt == EDGE_LAST);
   assign drive_now  = edge_now && (mode_q.cpha ? leading : (!leading && !last_edge));
   assign sample_now = edge_now && (mode_q.cpha ? !leading : leading);
   assign in_bit     = loop ? mosi_q : miso;
   assign rx_nxt     = sample_now ? step_in(rx_sh, in_bit, mode_q.lsb_first) : rx_sh;
   assign rx_word    = rx_nxt;
   assign done       = edge_now && last_edge;
   assign sck        = sck_q;
   assign mosi       = mosi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         mode_q   <= '0;
         div_cnt  <= '0;
         edge_cnt <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         sck_q    <= 1'b0;
         mosi_q   <= 1'b0;
      end else if (!busy) begin
         sck_q    <= mode.cpol;
         div_cnt  <= '0;
         edge_cnt <= '0;
         if (start) begin
            busy   <= 1'b1;
            mode_q <= mode;
            rx_sh  <= '0;
            if (mode.cpha) begin
               tx_sh <= word_in;
            end else begin
               mosi_q <= out_bit(word_in, mode.lsb_first);
               tx_sh  <= step_out(word_in, mode.lsb_first);
            end
         end
      end else begin
         div_cnt <= edge_now ? '0 : div_cnt + 1'b1;
         rx_sh   <= rx_nxt;
         if (edge_now) begin
            sck_q    <= !sck_q;
            edge_cnt <= edge_cnt + 1'b1;
            if (last_edge) busy <= 1'b0;
         end
         if (drive_now) begin
            mosi_q <= out_bit(tx_sh, mode_q.lsb_first);
            tx_sh  <= step_out(tx_sh, mode_q.lsb_first);
         end
      end
   end
endmodule

// File: rtl/spi_host_ctrl.sv
`timescale 1ns/1ps
module spi_host_ctrl
   import spi_host_pkg::*;
#(
   parameter int WORD_W     = 8,
   parameter int FIFO_DEPTH = 4,
   parameter int NUM_SS     = 4,
   parameter int SCK_HALF   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_SS-1:0] ss_n,
   input  logic              fault_sel_n,
   output logic              tx_done,
   output logic              tx_overrun,
   output logic              rx_underrun
);
   // elaboration-time parameter checks
   if (!(WORD_W == 8 || WORD_W == 16 || WORD_W == 32)) begin : g_bad_width
      $error("WORD_W must be 8, 16 or 32");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 2");
   end
   if (NUM_SS < 1 || NUM_SS > 32) begin : g_bad_ss
      $error("NUM_SS must lie in 1..32");
   end
   if (SCK_HALF < 1) begin : g_bad_div
      $error("SCK_HALF must be at least 1");
   end

   ctrl_t             ctrl_q, ctrl_wr;
   logic [NUM_SS-1:0] ssel_q;
   logic              fault_q;
   logic [1:0]        fsync_q;
   logic              wr_ctrl, wr_stat, wr_txd, wr_ssel, rd_rxd;
   logic              tx_clr, rx_clr;
   logic [WORD_W-1:0] tx_dout, rx_dout, sh_rx;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic              sh_busy, sh_done, sh_start;
   logic              unused_wdata;
   wire_mode_t        cur_mode;

   assign unused_wdata = ^bus_wdata;

   assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
   assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
   assign wr_txd  = bus_wr && (bus_addr == OFS_TXD);
   assign wr_ssel = bus_wr && (bus_addr == OFS_SSEL);
   assign rd_rxd  = bus_rd && (bus_addr == OFS_RXD);

   always_comb begin
      ctrl_wr        = ctrl_t'(bus_wdata[9:0]);
      ctrl_wr.tx_clr = 1'b0;
      ctrl_wr.rx_clr = 1'b0;
   end
   assign tx_clr = wr_ctrl && bus_wdata[5];
   assign rx_clr = wr_ctrl && bus_wdata[6];

   assign sh_start = ctrl_q.enable && ctrl_q.master && !ctrl_q.hold && !fault_q &&
                     !tx_empty && !sh_busy;
   assign cur_mode = '{cpol: ctrl_q.cpol, cpha: ctrl_q.cpha, lsb_first: ctrl_q.lsb_first};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         ssel_q      <= '1;
         fault_q     <= 1'b0;
         fsync_q     <= 2'b11;
         tx_done     <= 1'b0;
         tx_overrun  <= 1'b0;
         rx_underrun <= 1'b0;
      end else begin
         fsync_q <= {fsync_q[0], fault_sel_n};
         if (wr_ctrl) ctrl_q <= ctrl_wr;
         if (wr_ssel) ssel_q <= bus_wdata[NUM_SS-1:0];
         if (ctrl_q.enable && ctrl_q.master && !fsync_q[1])
            fault_q <= 1'b1;
         else if (wr_stat && bus_wdata[STAT_FAULT_BIT])
            fault_q <= 1'b0;
         tx_done     <= sh_done && tx_empty;
         tx_overrun  <= wr_txd && tx_full;
         rx_underrun <= rd_rxd && rx_empty;
      end
   end

   spi_host_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr),
      .push(wr_txd), .din(bus_wdata[WORD_W-1:0]), .pop(sh_start),
      .dout(tx_dout), .empty(tx_empty), .full(tx_full)
   );

   spi_host_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr),
      .push(sh_done), .din(sh_rx), .pop(rd_rxd),
      .dout(rx_dout), .empty(rx_empty), .full(rx_full)
   );

   spi_host_shifter #(.W(WORD_W), .SCK_HALF(SCK_HALF)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .word_in(tx_dout),
      .mode(cur_mode), .loop(ctrl_q.loop), .miso(miso),
      .busy(sh_busy), .sck(sck), .mosi(mosi), .done(sh_done), .rx_word(sh_rx)
   );

   for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
      assign ss_n[i] = (ctrl_q.manual_ss || sh_busy) ? ssel_q[i] : 1'b1;
   end

   always_comb begin
      unique case (bus_addr)
         OFS_CTRL: bus_rdata = 32'(ctrl_q);
         OFS_STAT: bus_rdata = {27'd0, fault_q, tx_full, tx_empty, rx_full, rx_empty};
         OFS_RXD:  bus_rdata = rx_empty ? 32'd0 : 32'(rx_dout);
         OFS_SSEL: bus_rdata = 32'(ssel_q);
         default:  bus_rdata = 32'd0;
      endcase
   end
endmodule

// File: rtl/spi_host_chk.sv
`timescale 1ns/1ps
module spi_host_chk #(
   parameter int NUM_SS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              hold,
   input logic              cpol,
   input logic              manual,
   input logic              sck,
   input logic [NUM_SS-1:0] ss_n,
   input logic              tx_clr,
   input logic              tx_empty,
   input logic              tx_full,
   input logic              rx_empty,
   input logic              tx_done,
   input logic              tx_overrun,
   input logic              rx_underrun
);
   p_hold_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !busy) |=> !busy);

   p_sck_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!busy) |-> (sck == $past(cpol)));

   p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tx_clr) |-> tx_empty);

   p_overrun_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_overrun |-> $past(tx_full));

   p_underrun_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_underrun |-> $past(rx_empty));

   p_done_drained_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> $past(tx_empty));

   p_auto_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!manual && !busy) |-> (&ss_n));
endmodule

bind spi_host_ctrl spi_host_chk #(.NUM_SS(NUM_SS)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(sh_busy), .hold(ctrl_q.hold),
   .cpol(ctrl_q.cpol), .manual(ctrl_q.manual_ss), .sck(sck), .ss_n(ss_n),
   .tx_clr(tx_clr), .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty),
   .tx_done(tx_done), .tx_overrun(tx_overrun), .rx_underrun(rx_underrun)
);

// File: tb/tb_spi_host_ctrl.sv
`timescale 1ns/1ps
module tb_spi_host_ctrl;
   localparam int W = 8;
   localparam int NS = 4;
   localparam int HALF = 2;
   localparam real TCLK = 5.0;
   localparam int NVEC = 8;
   // {cpol, cpha, lsb_first, tx word, slave reply}
   localparam logic [18:0] VEC [NVEC] = '{
      {3'b000, 8'h1D, 8'h6B}, {3'b010, 8'h2E, 8'h71},
      {3'b100, 8'h4C, 8'h93}, {3'b110, 8'h87, 8'h35},
      {3'b001, 8'h1D, 8'h6B}, {3'b011, 8'hE2, 8'h0F},
      {3'b101, 8'h58, 8'hA6}, {3'b111, 8'h3B, 8'hC4}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic sck, mosi, miso, fault_sel_n = 1'b1;
   logic [NS-1:0] ss_n;
   logic tx_done, tx_overrun, rx_underrun;

   int n_cmp = 0, n_bad = 0;

   always #(TCLK/2) clk = !clk;

   spi_host_ctrl #(.WORD_W(W), .FIFO_DEPTH(4), .NUM_SS(NS), .SCK_HALF(HALF)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
      .miso(miso), .ss_n(ss_n), .fault_sel_n(fault_sel_n), .tx_done(tx_done),
      .tx_overrun(tx_overrun), .rx_underrun(rx_underrun));

   // behavioural slave
   logic s_on = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0, s_lsb = 1'b0;
   logic [W-1:0] s_resp = '0, s_cap = '0;
   logic [W-1:0] cap_mem [32];
   int cap_n = 0, lead_n = 0, trail_n = 0, sck_tog = 0, gap_bad = 0;
   realtime t_last = 0;

   task automatic cap_bit(input int i);
      s_cap[s_lsb ? i : W-1-i] = mosi;
   endtask

   always @(sck) begin
      if (rst_n) sck_tog++;
      if (rst_n && s_on) begin
         if (lead_n + trail_n > 0 && ($realtime - t_last) != HALF * TCLK) gap_bad++;
         t_last = $realtime;
         if (sck !== s_cpol) begin
            lead_n++;
            if (!s_cpha) cap_bit(lead_n - 1);
         end else begin
            trail_n++;
            if (s_cpha) cap_bit(trail_n - 1);
            if (trail_n == W) begin
               cap_mem[cap_n % 32] = s_cap;
               cap_n++;
               lead_n = 0;
               trail_n = 0;
            end
         end
      end
   end

   always @* begin
      int idx;
      idx = s_cpha ? lead_n - 1 : trail_n;
      if (idx < 0 || idx >= W) miso = 1'b0;
      else miso = s_resp[s_lsb ? idx : W-1-idx];
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_done(output int pulses, input int cycles);
      pulses = 0;
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         if (tx_done) pulses++;
      end
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(150000 * TCLK);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      int p, tog0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R2 reset state
      peek(8'h60, d); chk("R1 ctrl after reset", d, 32'h0);
      peek(8'h64, d); chk("R2 status after reset", d, 32'h05);
      peek(8'h70, d); chk("R1 select reg after reset", d, 32'hF);
      chk("R1 ss_n after reset", 32'(ss_n), 32'hF);
      chk("R1 sck after reset", 32'(sck), 32'h0);

      wr(8'h70, 32'hE);

      // R4 / R5 / R6: table of modes against the slave model
      for (int k = 0; k < NVEC; k++) begin
         logic [2:0] m;
         logic [7:0] txw, rsp;
         {m, txw, rsp} = VEC[k];
         s_on = 1'b0;
         wr(8'h60, 32'h6 | (32'(m[2]) << 3) | (32'(m[1]) << 4) | (32'(m[0]) << 9));
         s_cpol = m[2]; s_cpha = m[1]; s_lsb = m[0]; s_resp = rsp;
         lead_n = 0; trail_n = 0;
         @(negedge clk);
         s_on = 1'b1;
         wr(8'h68, 32'(txw));
         wait_done(p, 60);
         chk("R10 one done pulse per word", 32'(p), 32'd1);
         rd(8'h6C, d);
         chk("R4 R5 R6 word received from slave", d, 32'(rsp));
         chk("R4 R5 word captured by slave", 32'(cap_mem[(cap_n - 1) % 32]), 32'(txw));
         chk("R4 sck rests at CPOL", 32'(sck), 32'(m[2]));
      end
      s_on = 1'b0;
      chk("R4 half-period spacing", 32'(gap_bad), 32'd0);

      // R3 / R7 / R9 / R10 / R6: held burst in loopback
      wr(8'h60, 32'h107);
      wr(8'h68, 32'h11); wr(8'h68, 32'h22); wr(8'h68, 32'h33); wr(8'h68, 32'h44);
      peek(8'h64, d); chk("R2 R3 status full TX, held", d, 32'h09);
      tog0 = sck_tog;
      repeat (40) @(negedge clk);
      chk("R3 no sck while held", 32'(sck_tog - tog0), 32'd0);
      peek(8'h64, d); chk("R3 TX kept while held", d, 32'h09);
      wr(8'h68, 32'h55);
      chk("R9 overrun pulse", 32'(tx_overrun), 32'h1);
      wr(8'h60, 32'h007);
      wait_done(p, 300);
      chk("R10 single pulse for burst", 32'(p), 32'd1);
      peek(8'h64, d); chk("R2 R6 RX full, TX empty", d, 32'h06);
      wr(8'h68, 32'h66);
      repeat (60) @(negedge clk);
      rd(8'h6C, d); chk("R6 R7 word 1 oldest first", d, 32'h11);
      rd(8'h6C, d); chk("R7 word 2", d, 32'h22);
      rd(8'h6C, d); chk("R7 word 3", d, 32'h33);
      rd(8'h6C, d); chk("R6 R7 word 4, overflow word dropped", d, 32'h44);
      peek(8'h64, d); chk("R6 RX drained", d, 32'h05);
      rd(8'h6C, d); chk("R9 empty read returns 0", d, 32'h0);
      chk("R9 underrun pulse", 32'(rx_underrun), 32'h1);

      // R8 FIFO clears
      wr(8'h60, 32'h107);
      wr(8'h68, 32'hA1); wr(8'h68, 32'hA2);
      peek(8'h64, d); chk("R8 TX loaded", d, 32'h01);
      wr(8'h60, 32'h127);
      peek(8'h64, d); chk("R8 TX clear empties", d, 32'h05);
      peek(8'h60, d); chk("R8 clear bits read 0, loopback kept", d, 32'h107);
      wr(8'h60, 32'h007);
      wr(8'h68, 32'h77);
      repeat (50) @(negedge clk);
      peek(8'h64, d); chk("R8 RX holds word", d, 32'h04);
      wr(8'h60, 32'h047);
      peek(8'h64, d); chk("R8 RX clear empties", d, 32'h05);

      // R11 slave-select modes
      wr(8'h60, 32'h006);
      chk("R11 auto idle deselects", 32'(ss_n), 32'hF);
      wr(8'h60, 32'h086);
      chk("R11 manual follows register", 32'(ss_n), 32'hE);
      wr(8'h70, 32'hFFFF_FFFB);
      chk("R11 manual selects slave 2", 32'(ss_n), 32'hB);
      wr(8'h70, 32'hE);
      wr(8'h60, 32'h006);
      wr(8'h68, 32'h3C);
      repeat (3) @(negedge clk);
      chk("R11 auto selects while shifting", 32'(ss_n), 32'hE);
      wait_done(p, 50);
      chk("R11 auto releases after word", 32'(ss_n), 32'hF);
      wr(8'h60, 32'h046);

      // R12 mode fault lockout
      wr(8'h60, 32'h007);
      @(negedge clk); fault_sel_n = 1'b0;
      repeat (4) @(negedge clk); fault_sel_n = 1'b1;
      repeat (2) @(negedge clk);
      peek(8'h64, d); chk("R12 fault flagged", d, 32'h15);
      wr(8'h68, 32'h5C);
      repeat (40) @(negedge clk);
      peek(8'h64, d); chk("R12 fault blocks start", d, 32'h11);
      wr(8'h64, 32'h10);
      wait_done(p, 50);
      rd(8'h6C, d); chk("R12 word sent after clearing fault", d, 32'h5C);
      peek(8'h64, d); chk("R12 fault cleared", d, 32'h05);

      finish_run();
   end
endmodule